// File: doc/BRIEF.md
# Partial-Scan Test Sequencer

This block drives the test of a logic region in which only part of the flip-flops sit on a scan chain. It produces two clock enables, one for the scanned flip-flops and one for the flip-flops that are not scanned. It also produces the scan-mode select line `tc`. It feeds the chain input and watches the chain output. In scan mode only the scanned flip-flops are clocked, so the state of the non-scanned flip-flops stays frozen while the chain shifts. In normal mode both groups are clocked together for one capture cycle.

After `start`, the block first shifts a fixed integrity pattern through the chain, for the chain length plus four clocks, and checks that the pattern comes back out. It then takes `N_VEC + 1` words over a valid/ready handshake.

Each word holds:
- the stimulus bits to shift in;
- the response bits expected to leave the chain during that same shift;
- a care mask over those response bits.

Every word except the last is followed by one capture cycle. The last word only unloads the response to the final capture. Each bit that leaves the chain is compared one cycle after its shift. Disagreements on care positions are counted, and `done` rises once the last comparison has been made.

Top module: `pscan_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `tc`, `sff_ce`, `nff_ce`, `vec_ready` and `done` are 0 and `mismatch_cnt` is 0.
- R2: Whenever `tc` is 1, `nff_ce` is 0. Whenever `nff_ce` is 1, `sff_ce` is also 1 and `tc` is 0.
- R3: `tc` changes value only between two consecutive cycles in both of which `sff_ce` and `nff_ce` are 0.
- R4: After `start` the block shifts N_SFF+4 times with `tc`=1, driving `scan_in` with the pattern 0,0,1,1 repeated (bit i of the flush is bit 1 of i). For flush shift i with i >= N_SFF, the bit leaving the chain must equal flush bit i-N_SFF; any other value counts as a mismatch.
- R5: A word is accepted in a cycle where `vec_valid` and `vec_ready` are both 1. `vec_ready` is 1 only while a word is awaited, and no clock enable is active then. The accepted word is then shifted in with exactly N_SFF scan-mode shifts, `vec_si[j]` on shift j, starting at j = 0.
- R6: Exactly one capture cycle follows the shifts of each of the first N_VEC words. A capture cycle has `tc`=0 with both enables at 1. Each switch of `tc` is separated from the enables by one quiet cycle on each side.
- R7: The (N_VEC+1)-th word is shifted like the others but is not followed by a capture; the run then ends.
- R8: From `start` to `done`, `sff_ce` is 1 for exactly (N_VEC+2)*N_SFF + N_VEC + 4 cycles.
- R9: The bit leaving the chain on shift j of a word is compared with `vec_exp[j]` only if `vec_care[j]` is 1. Each disagreement raises `mismatch_cnt` by one. A position with `vec_care[j]`=0 never changes the count.
- R10: `done` rises only after the last comparison and then holds, with `mismatch_cnt` stable, until the next `start`. That `start` clears the count.
- R11: Stalling `vec_valid` only lengthens the wait; the enable count and the comparison results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test run (accepted when idle or done) |
| vec_valid | input | 1 | Test word offered |
| vec_ready | output | 1 | Sequencer waits for a word |
| vec_si | input | N_SFF | Stimulus bits, bit j shifted in on shift j |
| vec_exp | input | N_SFF | Expected chain output bit for shift j |
| vec_care | input | N_SFF | 1 = compare position j |
| tc | output | 1 | Scan-mode select (1 = shift) |
| sff_ce | output | 1 | Clock enable of scanned flip-flops |
| nff_ce | output | 1 | Clock enable of non-scanned flip-flops |
| scan_in | output | 1 | Serial data into the chain |
| scan_out | input | 1 | Serial data leaving the chain |
| done | output | 1 | Run complete, result valid |
| mismatch_cnt | output | MISM_W | Saturating count of compare failures |

## Verification
The bench runs the sequencer against its own small partial-scan circuit, with a rotating chain and a non-scanned accumulator, and a behavioural model of that circuit predicts every response.

The first run offers words with no stall and correct expectations. It pins the cycle-exact schedule of enables and `tc`, and expects zero mismatches.

The second run restarts from the finished state, with a stalling `vec_valid` and deliberately flipped expectations on some cared and some masked positions. This separates counting of care bits from counting of masked bits, and shows that stalls leave the schedule length intact.

The third run ties the chain output to 0. Every expected 1 in the flush window and in the words must then be counted, which proves that flush comparison and word comparison are both live.

// File: rtl/pscan_pkg.sv
package pscan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN1,
        ST_TURN2,
        ST_FLUSH,
        ST_LOAD,
        ST_SHIFT,
        ST_CAPT,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic tc;
        logic sff_ce;
        logic nff_ce;
    } clk_ctl_t;

    // Integrity pattern: 0,0,1,1 repeating
    function automatic logic flush_bit(input int unsigned idx);
        return idx[1];
    endfunction

    function automatic int unsigned sff_clock_total(input int unsigned n_sff,
                                                    input int unsigned n_vec);
        return (n_vec + 2) * n_sff + n_vec + 4;
    endfunction

endpackage

// File: rtl/pscan_ctrl.sv
module pscan_ctrl
    import pscan_pkg::*;
#(
    parameter int N_SFF = 8,
    parameter int N_VEC = 4,
    parameter int CNT_W = $clog2(N_SFF + 5),
    parameter int WC_W  = $clog2(N_VEC + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             vec_valid,
    output clk_ctl_t         ctl,
    output logic             vec_ready,
    output logic             load,
    output logic             shift_vec,
    output logic             in_flush,
    output logic [CNT_W-1:0] flush_idx,
    output logic             clear,
    output logic             done
);
    localparam int FLUSH_LEN = N_SFF + 4;
    localparam logic [WC_W-1:0] LAST_WORDS = WC_W'(N_VEC + 1);

    seq_state_e       state;
    logic             tc_q;
    logic             flushed;
    logic [CNT_W-1:0] shift_cnt;
    logic [WC_W-1:0]  word_cnt;

    assign clear = start && (state == ST_IDLE || state == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            tc_q      <= 1'b0;
            flushed   <= 1'b0;
            shift_cnt <= '0;
            word_cnt  <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state    <= ST_TURN1;
                        flushed  <= 1'b0;
                        word_cnt <= '0;
                    end
                end
                ST_TURN1: begin
                    tc_q  <= ~tc_q;
                    state <= ST_TURN2;
                end
                ST_TURN2: begin
                    shift_cnt <= '0;
                    if (tc_q)
                        state <= flushed ? ST_LOAD : ST_FLUSH;
                    else
                        state <= (word_cnt == LAST_WORDS) ? ST_DONE : ST_CAPT;
                end
                ST_FLUSH: begin
                    if (shift_cnt == CNT_W'(FLUSH_LEN - 1)) begin
                        shift_cnt <= '0;
                        flushed   <= 1'b1;
                        state     <= ST_LOAD;
                    end else begin
                        shift_cnt <= shift_cnt + 1'b1;
                    end
                end
                ST_LOAD: begin
                    if (vec_valid) begin
                        shift_cnt <= '0;
                        state     <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (shift_cnt == CNT_W'(N_SFF - 1)) begin
                        shift_cnt <= '0;
                        word_cnt  <= word_cnt + 1'b1;
                        state     <= ST_TURN1;
                    end else begin
                        shift_cnt <= shift_cnt + 1'b1;
                    end
                end
                ST_CAPT:  state <= ST_TURN1;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.tc     = tc_q;
        ctl.sff_ce = (state == ST_FLUSH) || (state == ST_SHIFT) || (state == ST_CAPT);
        ctl.nff_ce = (state == ST_CAPT);
    end

    assign vec_ready = (state == ST_LOAD);
    assign load      = vec_ready && vec_valid;
    assign shift_vec = (state == ST_SHIFT);
    assign in_flush  = (state == ST_FLUSH);
    assign flush_idx = shift_cnt;
    assign done      = (state == ST_DONE);

endmodule

// File: rtl/pscan_serial.sv
module pscan_serial
    import pscan_pkg::*;
#(
    parameter int N_SFF = 8,
    parameter int CNT_W = $clog2(N_SFF + 5)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             shift_vec,
    input  logic             in_flush,
    input  logic [CNT_W-1:0] flush_idx,
    input  logic [N_SFF-1:0] vec_si,
    input  logic [N_SFF-1:0] vec_exp,
    input  logic [N_SFF-1:0] vec_care,
    output logic             scan_in,
    output logic             exp_bit,
    output logic             care_bit
);
    logic [N_SFF-1:0] si_q, exp_q, care_q;
    logic [CNT_W-1:0] back_idx;

    // Position in the pattern that should be emerging now
    assign back_idx = flush_idx - CNT_W'(N_SFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            si_q   <= '0;
            exp_q  <= '0;
            care_q <= '0;
        end else if (load) begin
            si_q   <= vec_si;
            exp_q  <= vec_exp;
            care_q <= vec_care;
        end else if (shift_vec) begin
            si_q   <= si_q   >> 1;
            exp_q  <= exp_q  >> 1;
            care_q <= care_q >> 1;
        end
    end

    always_comb begin
        if (in_flush) begin
            scan_in  = flush_bit(int'(flush_idx));
            exp_bit  = flush_bit(int'(back_idx));
            care_bit = (flush_idx >= CNT_W'(N_SFF));
        end else begin
            scan_in  = si_q[0];
            exp_bit  = exp_q[0];
            care_bit = care_q[0] && shift_vec;
        end
    end

endmodule

// File: rtl/pscan_cmp.sv
module pscan_cmp #(
    parameter int MISM_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              exp_bit,
    input  logic              care_bit,
    input  logic              scan_out,
    output logic [MISM_W-1:0] mismatch_cnt
);
    localparam logic [MISM_W-1:0] CNT_MAX = '1;

    logic pend, p_exp, p_got;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pend         <= 1'b0;
            p_exp        <= 1'b0;
            p_got        <= 1'b0;
            mismatch_cnt <= '0;
        end else begin
            pend  <= shift_en && care_bit;
            p_exp <= exp_bit;
            p_got <= scan_out;
            if (pend && (p_exp != p_got) && (mismatch_cnt != CNT_MAX))
                mismatch_cnt <= mismatch_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pscan_seq.sv
module pscan_seq
    import pscan_pkg::*;
#(
    parameter int N_SFF  = 8,
    parameter int N_VEC  = 4,
    parameter int MISM_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              vec_valid,
    output logic              vec_ready,
    input  logic [N_SFF-1:0]  vec_si,
    input  logic [N_SFF-1:0]  vec_exp,
    input  logic [N_SFF-1:0]  vec_care,
    output logic              tc,
    output logic              sff_ce,
    output logic              nff_ce,
    output logic              scan_in,
    input  logic              scan_out,
    output logic              done,
    output logic [MISM_W-1:0] mismatch_cnt
);
    localparam int CNT_W = $clog2(N_SFF + 5);

    clk_ctl_t         ctl;
    logic             load, shift_vec, in_flush, clear;
    logic [CNT_W-1:0] flush_idx;
    logic             exp_bit, care_bit;

    pscan_ctrl #(.N_SFF(N_SFF), .N_VEC(N_VEC), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .vec_valid(vec_valid),
        .ctl(ctl), .vec_ready(vec_ready), .load(load), .shift_vec(shift_vec),
        .in_flush(in_flush), .flush_idx(flush_idx), .clear(clear), .done(done)
    );

    pscan_serial #(.N_SFF(N_SFF), .CNT_W(CNT_W)) u_ser (
        .clk(clk), .rst(rst), .load(load), .shift_vec(shift_vec),
        .in_flush(in_flush), .flush_idx(flush_idx),
        .vec_si(vec_si), .vec_exp(vec_exp), .vec_care(vec_care),
        .scan_in(scan_in), .exp_bit(exp_bit), .care_bit(care_bit)
    );

    pscan_cmp #(.MISM_W(MISM_W)) u_cmp (
        .clk(clk), .rst(rst), .clear(clear),
        .shift_en(shift_vec || in_flush), .exp_bit(exp_bit),
        .care_bit(care_bit), .scan_out(scan_out), .mismatch_cnt(mismatch_cnt)
    );

    assign tc     = ctl.tc;
    assign sff_ce = ctl.sff_ce;
    assign nff_ce = ctl.nff_ce;

endmodule

// File: rtl/pscan_seq_chk.sv
module pscan_seq_chk #(
    parameter int MISM_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              vec_ready,
    input logic              tc,
    input logic              sff_ce,
    input logic              nff_ce,
    input logic              done,
    input logic [MISM_W-1:0] mismatch_cnt
);
    p_scan_freeze_r2: assert property (@(posedge clk) disable iff (rst)
        tc |-> !nff_ce);

    p_capture_pair_r2: assert property (@(posedge clk) disable iff (rst)
        nff_ce |-> (sff_ce && !tc));

    p_tc_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (tc != $past(tc)) |-> (!sff_ce && !nff_ce && !$past(sff_ce) && !$past(nff_ce)));

    p_ready_idle_r5: assert property (@(posedge clk) disable iff (rst)
        vec_ready |-> (!sff_ce && !nff_ce && tc));

    p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(start) |-> (mismatch_cnt == $past(mismatch_cnt) ||
                           mismatch_cnt == $past(mismatch_cnt) + 1'b1));

    p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(mismatch_cnt)));

    p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!sff_ce && !vec_ready));

endmodule

bind pscan_seq pscan_seq_chk #(.MISM_W(MISM_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .vec_ready(vec_ready), .tc(tc),
    .sff_ce(sff_ce), .nff_ce(nff_ce), .done(done), .mismatch_cnt(mismatch_cnt)
);

// File: tb/tb_pscan_seq.sv
module tb_pscan_seq;
    localparam int N  = 8;
    localparam int NV = 4;
    localparam int MW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic vec_valid, vec_ready;
    logic [N-1:0] vec_si, vec_exp, vec_care;
    logic tc, sff_ce, nff_ce, scan_in, scan_out, done;
    logic [MW-1:0] mismatch_cnt;

    always #2 clk = ~clk;

    pscan_seq #(.N_SFF(N), .N_VEC(NV), .MISM_W(MW)) dut (
        .clk(clk), .rst(rst), .start(start), .vec_valid(vec_valid),
        .vec_ready(vec_ready), .vec_si(vec_si), .vec_exp(vec_exp),
        .vec_care(vec_care), .tc(tc), .sff_ce(sff_ce), .nff_ce(nff_ce),
        .scan_in(scan_in), .scan_out(scan_out), .done(done),
        .mismatch_cnt(mismatch_cnt)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // Circuit under test: scan chain plus a non-scanned accumulator
    logic [N-1:0] chain;
    logic [3:0]   nff_m;
    bit           stuck0 = 1'b0;
    assign scan_out = stuck0 ? 1'b0 : chain[N-1];

    always @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            nff_m <= '0;
        end else begin
            if (start) nff_m <= '0;
            else if (nff_ce) nff_m <= chain[3:0] + nff_m;
            if (sff_ce) begin
                if (tc) chain <= {chain[N-2:0], scan_in};
                else    chain <= {chain[N-2:0], chain[N-1]} ^ N'(nff_m);
            end
        end
    end

    // Word source
    logic [N-1:0] si_a [NV+1];
    logic [N-1:0] exp_a[NV+1];
    logic [N-1:0] care_a[NV+1];
    int  widx;
    bit  wrst = 1'b0;
    bit  stall_en = 1'b0;

    assign vec_valid = stall_en ? (cyc % 3 != 1) : 1'b1;
    assign vec_si    = (widx <= NV) ? si_a[widx]   : '0;
    assign vec_exp   = (widx <= NV) ? exp_a[widx]  : '0;
    assign vec_care  = (widx <= NV) ? care_a[widx] : '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wrst) widx <= 0;
        else if (vec_valid && vec_ready) widx <= widx + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Behavioural prediction of the circuit responses
    task automatic prepare(input int seed);
        logic [N-1:0] ch = '0;
        logic [3:0]   nf = '0;
        logic [N-1:0] nx;
        for (int i = 0; i < N + 4; i++) ch = {ch[N-2:0], 1'(i >> 1)};
        for (int k = 0; k <= NV; k++) begin
            si_a[k]   = N'((k * 37 + seed) ^ (k << 3));
            care_a[k] = '1;
            for (int j = 0; j < N; j++) begin
                exp_a[k][j] = ch[N-1];
                ch = {ch[N-2:0], si_a[k][j]};
            end
            if (k < NV) begin
                nx = {ch[N-2:0], ch[N-1]} ^ N'(nf);
                nf = ch[3:0] + nf;
                ch = nx;
            end
        end
    endtask

    // Expected per-cycle schedule {tc, sff_ce, nff_ce, vec_ready}
    logic [3:0] tl[$];
    task automatic push(input logic [3:0] v, input int n);
        for (int i = 0; i < n; i++) tl.push_back(v);
    endtask
    task automatic build_timeline();
        tl.delete();
        push(4'b0000, 1); push(4'b1000, 1);
        push(4'b1100, N + 4);
        for (int k = 0; k <= NV; k++) begin
            push(4'b1001, 1);
            push(4'b1100, N);
            push(4'b1000, 1); push(4'b0000, 1);
            if (k < NV) begin
                push(4'b0110, 1); push(4'b0000, 1); push(4'b1000, 1);
            end
        end
    endtask

    // Every clock: mode rules (R2, R3)
    logic ptc = 1'b0, psff = 1'b0, pnff = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            check(!(tc && nff_ce), "R2 nff_ce in scan mode", int'(nff_ce), 0);
            check(!nff_ce || (sff_ce && !tc), "R2 capture enables", int'(sff_ce), 1);
            check(tc == ptc || (!sff_ce && !nff_ce && !psff && !pnff),
                  "R3 tc switched with enable active", int'(sff_ce | psff), 0);
        end
        ptc  <= tc;
        psff <= sff_ce;
        pnff <= nff_ce;
    end

    task automatic run_seq(input bit use_tl, input int exp_mism, input string tag);
        int nsff = 0;
        int guard = 0;
        logic [3:0] e;
        wrst = 1'b1;
        @(negedge clk);
        wrst = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(mismatch_cnt == 0, {"R10 cleared by start ", tag}, int'(mismatch_cnt), 0);
        while (!done && guard < 5000) begin
            if (use_tl) begin
                e = (tl.size() > 0) ? tl.pop_front() : 4'b0000;
                check({tc, sff_ce, nff_ce, vec_ready} == e,
                      "R4 R5 R6 R7 schedule", int'({tc, sff_ce, nff_ce, vec_ready}), int'(e));
            end
            if (sff_ce) nsff++;
            guard++;
            @(negedge clk);
        end
        if (use_tl) check(tl.size() == 0, "R7 run ended early/late", tl.size(), 0);
        check(nsff == (NV + 2) * N + NV + 4, {"R8 enable count ", tag}, nsff, (NV + 2) * N + NV + 4);
        check(mismatch_cnt == MW'(exp_mism), {"R9 mismatches ", tag}, int'(mismatch_cnt), exp_mism);
        repeat (3) @(negedge clk);
        check(done == 1'b1, "R10 done holds", int'(done), 1);
        check(mismatch_cnt == MW'(exp_mism), "R10 count stable", int'(mismatch_cnt), exp_mism);
    endtask

    initial begin : wd
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int ones;
        prepare(11);
        repeat (3) @(negedge clk);
        check({tc, sff_ce, nff_ce, vec_ready, done} == 5'b0, "R1 reset outputs",
              int'({tc, sff_ce, nff_ce, vec_ready, done}), 0);
        check(mismatch_cnt == 0, "R1 reset count", int'(mismatch_cnt), 0);
        rst = 1'b0;
        @(negedge clk);
        check({tc, sff_ce, nff_ce, vec_ready, done} == 5'b0, "R1 after reset",
              int'({tc, sff_ce, nff_ce, vec_ready, done}), 0);

        // Run 1: no stall, exact expectations, cycle-exact schedule
        build_timeline();
        run_seq(1'b1, 0, "clean");

        // Run 2: restart from done, stalls, corrupted cared and masked bits
        prepare(53);
        exp_a[0][0] = ~exp_a[0][0];
        exp_a[1][2] = ~exp_a[1][2];
        exp_a[2][5] = ~exp_a[2][5];
        care_a[2][5] = 1'b0;
        stall_en = 1'b1;
        run_seq(1'b0, 2, "R11 stalled");
        stall_en = 1'b0;

        // Run 3: chain output stuck at 0, flush check and word checks live
        prepare(90);
        ones = 2;
        for (int k = 0; k <= NV; k++) ones += $countones(exp_a[k]);
        stuck0 = 1'b1;
        run_seq(1'b0, ones, "R4 stuck");
        stuck0 = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule